// File: doc/BRIEF.md
# Serial Port FIFO Status Unit

This block keeps the status and error flags of a frame-synchronized serial port. It owns a small transmit FIFO, filled by software through a register write port and drained by a shifter stub with load strobes. It also owns a receive FIFO, filled by the shifter stub and drained by a pop strobe. It raises a receive data request when the receive FIFO holds more words than a programmable watermark.

It flags three error conditions:
- a frame sync that arrives before the current frame's slots have all passed;
- a software write into a full transmit FIFO;
- a load request while the transmit FIFO is empty.

Each error flag is sticky and is cleared by writing 1 to it. An early frame sync does not stop traffic: the slots still transfer. On underrun the shifter word is left as it was, so the previous word goes out again. Each flag drives the transmit or receive interrupt line through its own enable bit.

Software uses four write addresses:

| Address | Function |
|---|---|
| 0 | Push a transmit word |
| 1 | Write-1-to-clear the error flags |
| 2 | Control: enables and watermark |
| 3 | Interrupt enables |

Top module: `serport_status`

## Requirements
- R1: After reset, all flags and both interrupts are 0, both FIFO levels are 0 and `tx_word` is all zeros.
- R2: `status[0]` (receive data request) is 1 exactly when `rx_level` is greater than the watermark. The watermark is written to address 2, bits [6:2].
- R3: `status[1]` (frame error) is set when `fsync` arrives while a frame is open and fewer than FRAME_WORDS `slot_tick` pulses have been seen since the previous `fsync`. The transmit or receive enable must also be 1. The first `fsync` after reset never sets it.
- R4: A frame error does not block transfers. Loads, stores and slot counting continue, and the new `fsync` starts a fresh frame.
- R5: `status[2]` (overrun) is set by a write to address 0 while the transmit FIFO holds DEPTH words. The written word is discarded and the FIFO contents and order are kept.
- R6: `status[3]` (underrun) is set by `tx_load` while the transmit FIFO is empty, and `tx_word` keeps its previous value.
- R7: `tx_load` with a non-empty transmit FIFO moves the oldest word into `tx_word` on the next clock edge (first in, first out).
- R8: A write to address 1 clears each error flag whose bit among [3:1] is 1, and leaves flags written with 0 unchanged. A hardware set in the same cycle as a clear wins.
- R9: Overrun and underrun are only flagged while the transmit enable (address 2, bit 0) is 1. Frame error is only flagged while the transmit enable or the receive enable (address 2, bit 1) is 1.
- R10: The interrupt enables are at address 3, bits [3:0], one per status bit. `tx_irq` is the OR of status bits 1 to 3, each masked by its enable. `rx_irq` is `status[0]` masked by enable bit 0.
- R11: `rx_store` pushes `rx_in` unless the receive FIFO is full, in which case the word is dropped. `rx_pop` removes the head, and `rx_data` shows the oldest word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register write address |
| reg_wdata | input | W | Register write data |
| fsync | input | 1 | Frame sync pulse |
| slot_tick | input | 1 | One pulse per slot transferred |
| tx_load | input | 1 | Shifter requests the next transmit word |
| rx_store | input | 1 | Shifter delivers a received word |
| rx_in | input | W | Received word |
| rx_pop | input | 1 | Remove the head of the receive FIFO |
| tx_word | output | W | Word currently held by the shifter |
| rx_data | output | W | Head of the receive FIFO |
| tx_level | output | CW | Transmit FIFO fill level |
| rx_level | output | CW | Receive FIFO fill level |
| status | output | 4 | {underrun, overrun, frame error, receive request} |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The fill counters, the frame slot counter and the flags all feed outputs within one clock. A count that drifts therefore shows as a wrong `tx_level` or `rx_level` on the next cycle. A misplaced read pointer shows as a wrong `tx_word` on the next load, or a wrong `rx_data` at once. A slot counter that misses a tick shows as a frame error flag set, or not set, on the next `fsync`. A behavioural model with queues is compared against every output on every clock, so any such divergence is reported within the cycle it first reaches a port.

// File: rtl/serport_status.sv
module serport_status #(
  parameter int W = 32,
  parameter int DEPTH = 16,
  parameter int FRAME_WORDS = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [W-1:0]  reg_wdata,
  input  logic          fsync,
  input  logic          slot_tick,
  input  logic          tx_load,
  input  logic          rx_store,
  input  logic [W-1:0]  rx_in,
  input  logic          rx_pop,
  output logic [W-1:0]  tx_word,
  output logic [W-1:0]  rx_data,
  output logic [CW-1:0] tx_level,
  output logic [CW-1:0] rx_level,
  output logic [3:0]    status,
  output logic          tx_irq,
  output logic          rx_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int FW = $clog2(FRAME_WORDS + 1);

  logic          txe, rxe;
  logic [CW-1:0] wmark;
  logic [3:0]    ien;
  logic          f_fs, f_ov, f_ud;
  logic          in_frame;
  logic [FW-1:0] fcnt;

  logic [W-1:0]  tx_mem [DEPTH];
  logic [W-1:0]  rx_mem [DEPTH];
  logic [AW-1:0] tx_rp, tx_wp, rx_rp, rx_wp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire wr_tx   = reg_we && reg_addr == 2'd0;
  wire wr_clr  = reg_we && reg_addr == 2'd1;
  wire wr_ctl  = reg_we && reg_addr == 2'd2;
  wire wr_ien  = reg_we && reg_addr == 2'd3;

  wire tx_full  = tx_cnt == CW'(DEPTH);
  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt == CW'(DEPTH);
  wire rx_empty = rx_cnt == '0;

  wire tx_push = wr_tx && !tx_full;
  wire tx_pop  = tx_load && !tx_empty;
  wire rx_push = rx_store && !rx_full;
  wire rx_take = rx_pop && !rx_empty;

  wire frame_short = in_frame && (fcnt < FW'(FRAME_WORDS));
  wire set_fs = fsync && (txe || rxe) && frame_short;
  wire set_ov = wr_tx && tx_full && txe;
  wire set_ud = tx_load && tx_empty && txe;
  wire [2:0] clr = wr_clr ? reg_wdata[3:1] : 3'b000;

  wire rdreq = rx_cnt > wmark;

  assign status   = {f_ud, f_ov, f_fs, rdreq};
  assign tx_irq   = |({f_ud, f_ov, f_fs} & ien[3:1]);
  assign rx_irq   = rdreq & ien[0];
  assign tx_level = tx_cnt;
  assign rx_level = rx_cnt;
  assign rx_data  = rx_mem[rx_rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe   <= 1'b0;
      rxe   <= 1'b0;
      wmark <= '0;
      ien   <= '0;
    end else begin
      if (wr_ctl) begin
        txe   <= reg_wdata[0];
        rxe   <= reg_wdata[1];
        wmark <= reg_wdata[2 +: CW];
      end
      if (wr_ien) ien <= reg_wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_fs <= 1'b0;
      f_ov <= 1'b0;
      f_ud <= 1'b0;
    end else begin
      f_fs <= (f_fs & ~clr[0]) | set_fs;
      f_ov <= (f_ov & ~clr[1]) | set_ov;
      f_ud <= (f_ud & ~clr[2]) | set_ud;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      fcnt     <= '0;
    end else if (fsync) begin
      in_frame <= 1'b1;
      fcnt     <= '0;
    end else if (slot_tick && frame_short) begin
      fcnt <= fcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rp   <= '0;
      tx_wp   <= '0;
      tx_cnt  <= '0;
      tx_word <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop) begin
        tx_rp   <= tx_rp + 1'b1;
        tx_word <= tx_mem[tx_rp];
      end
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= reg_wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rp  <= '0;
      rx_wp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_take) rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_take);
    end
  end

  p_ovr_keeps_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && tx_full && !tx_load) |=> tx_level == CW'(DEPTH));

  p_udr_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && tx_empty) |=> $stable(tx_word));

  p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && (txe || rxe) && frame_short) |=> status[1]);

  p_ovr_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!txe && !status[2]) |=> !status[2]);

  p_udr_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!txe && !status[3]) |=> !status[3]);

  p_rx_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= CW'(DEPTH));

  p_rx_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_level > '0);
endmodule

// File: tb/serport_status_tb.sv
module serport_status_tb_top;
  localparam int W = 32;
  localparam int DEPTH = 16;
  localparam int FWORDS = 2;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 0, fsync = 0, slot_tick = 0, tx_load = 0, rx_store = 0, rx_pop = 0;
  logic [1:0] reg_addr = 0;
  logic [W-1:0] reg_wdata = 0, rx_in = 0;
  logic [W-1:0] tx_word, rx_data;
  logic [CW-1:0] tx_level, rx_level;
  logic [3:0] status;
  logic tx_irq, rx_irq;

  always #4 clk = ~clk;

  serport_status #(.W(W), .DEPTH(DEPTH), .FRAME_WORDS(FWORDS)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .fsync(fsync), .slot_tick(slot_tick), .tx_load(tx_load), .rx_store(rx_store),
    .rx_in(rx_in), .rx_pop(rx_pop), .tx_word(tx_word), .rx_data(rx_data),
    .tx_level(tx_level), .rx_level(rx_level), .status(status), .tx_irq(tx_irq), .rx_irq(rx_irq));

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [W-1:0] txq[$], rxq[$];
  logic [W-1:0] m_word = 0;
  logic [2:0] m_flags = 0;
  bit m_txe = 0, m_rxe = 0, m_in = 0;
  int m_wm = 0, m_cnt = 0;
  logic [3:0] m_ien = 0;

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [2:0] clr, set;
    bit was_empty, was_full;
    clr = (reg_we && reg_addr == 2'd1) ? reg_wdata[3:1] : 3'b000;
    set = 3'b000;
    set[0] = fsync && (m_txe || m_rxe) && m_in && m_cnt < FWORDS;
    if (fsync) begin m_in = 1; m_cnt = 0; end
    else if (slot_tick && m_in && m_cnt < FWORDS) m_cnt++;
    was_empty = txq.size() == 0;
    was_full = txq.size() == DEPTH;
    if (tx_load) begin
      if (was_empty) set[2] = m_txe;
      else m_word = txq.pop_front();
    end
    if (reg_we && reg_addr == 2'd0) begin
      if (was_full) set[1] = m_txe;
      else txq.push_back(reg_wdata);
    end
    was_full = rxq.size() == DEPTH;
    if (rx_pop && rxq.size() > 0) void'(rxq.pop_front());
    if (rx_store && !was_full) rxq.push_back(rx_in);
    m_flags = (m_flags & ~clr) | set;
    if (reg_we && reg_addr == 2'd2) begin
      m_txe = reg_wdata[0]; m_rxe = reg_wdata[1]; m_wm = int'(reg_wdata[6:2]);
    end
    if (reg_we && reg_addr == 2'd3) m_ien = reg_wdata[3:0];
  endtask

  task automatic compare();
    bit rq;
    rq = rxq.size() > m_wm;
    chk("R2 rdreq", W'(status[0]), W'(rq));
    chk("R3 frame error", W'(status[1]), W'(m_flags[0]));
    chk("R5 overrun", W'(status[2]), W'(m_flags[1]));
    chk("R6 underrun", W'(status[3]), W'(m_flags[2]));
    chk("R7 tx_word", tx_word, m_word);
    chk("R5 tx_level", W'(tx_level), W'(txq.size()));
    chk("R11 rx_level", W'(rx_level), W'(rxq.size()));
    if (rxq.size() > 0) chk("R11 rx_data", rx_data, rxq[0]);
    chk("R10 tx_irq", W'(tx_irq), W'(|(m_flags & m_ien[3:1])));
    chk("R10 rx_irq", W'(rx_irq), W'(rq & m_ien[0]));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    reg_we = 0; fsync = 0; slot_tick = 0; tx_load = 0; rx_store = 0; rx_pop = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d; cyc();
  endtask

  task automatic ld(); tx_load = 1; cyc(); endtask
  task automatic tick(); slot_tick = 1; cyc(); endtask
  task automatic fs(); fsync = 1; cyc(); endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", W'(status), 0);
    chk("R1 tx_word", tx_word, 0);
    chk("R1 levels", W'({tx_level, rx_level}), 0);
    chk("R1 irq", W'({tx_irq, rx_irq}), 0);
    rst_n = 1;
    cyc();
    // R9 disabled: underrun, overrun and frame error not flagged
    ld();
    fs(); fs();
    for (int i = 0; i < DEPTH + 2; i++) wr(2'd0, 32'hA000_0000 + i);
    for (int i = 0; i < DEPTH; i++) ld();
    wr(2'd2, (3 << 2) | 3);
    wr(2'd3, 4'hF);
    // R7 order, R6 underrun repeats last word
    wr(2'd0, 32'h1111_0001); wr(2'd0, 32'h1111_0002); wr(2'd0, 32'h1111_0003);
    ld(); ld(); ld(); ld(); ld();
    // R8 write 0 has no effect, write 1 clears
    wr(2'd1, 0); wr(2'd1, 4'b1000);
    // R5 fill and overrun, then drain in order
    for (int i = 0; i < DEPTH + 3; i++) wr(2'd0, 32'hB000_0000 + i);
    reg_we = 1; reg_addr = 0; reg_wdata = 32'hDEAD_BEEF; tx_load = 1; cyc();
    for (int i = 0; i < DEPTH + 1; i++) ld();
    wr(2'd1, 4'b1110);
    // R2, R11 receive side and watermark boundary
    for (int i = 0; i < 5; i++) begin rx_store = 1; rx_in = 32'hC000_0000 + i; cyc(); end
    rx_pop = 1; cyc(); rx_pop = 1; cyc();
    for (int i = 0; i < DEPTH + 2; i++) begin rx_store = 1; rx_in = 32'hD000_0000 + i; cyc(); end
    rx_store = 1; rx_pop = 1; rx_in = 32'hEEEE_0000; cyc();
    for (int i = 0; i < DEPTH; i++) begin rx_pop = 1; cyc(); end
    // R3 early sync sets error, R4 traffic continues
    wr(2'd0, 32'h2222_0001); wr(2'd0, 32'h2222_0002);
    fs(); tick(); fs();
    tx_load = 1; slot_tick = 1; cyc();
    tick(); fs();
    wr(2'd1, 4'b0010);
    tick(); tick(); tick(); fs();
    // R8 set beats clear in same cycle
    fsync = 1; reg_we = 1; reg_addr = 1; reg_wdata = 4'b0010; cyc();
    ld(); ld();
    // R10 masking
    wr(2'd3, 4'b0100); wr(2'd3, 4'b1000); wr(2'd3, 0);
    for (int i = 0; i < 6; i++) begin rx_store = 1; rx_in = i; cyc(); end
    wr(2'd3, 4'b0001);
    wr(2'd1, 4'b1110);
    // R9 rx enable alone keeps frame error live, tx flags off
    wr(2'd2, 2);
    fs(); fs(); ld();
    wr(2'd2, 0); wr(2'd1, 4'b0010); fs(); fs();
    repeat (3) cyc();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule